// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a processor access port and a slow memory that moves one word per transaction. It keeps a direct-mapped array of single-word lines, each with a valid flag, a tag and a data word. A load whose line is valid and whose tag matches returns its word combinationally in the cycle it is presented, with no stall.

When a load misses, the block raises its stall output and issues a word read to memory. When memory answers, it writes the returned word, the tag and the valid flag into the line. It then serves the held request again from the cache, and this time the request hits. Every store is written through to memory, and the processor stays stalled until memory acknowledges. A store that hits also updates the cached word. A store that misses leaves the cache untouched.

The processor holds its request, write flag, address and write data steady while stall is high. An access completes on the rising edge where `cpu_req` is high and `cpu_stall` is low.

Top module: `dmc_cache`

## Requirements
- R1: A byte address is split into a byte offset (the low 2 bits), an index of INDEX_W bits directly above it, and a tag made of all remaining upper bits. The index alone selects the line, and the tag must match for a hit.
- R2: After reset every line is invalid, so the first load to any line misses. With no request present, `cpu_stall` and `mem_req` are low.
- R3: A load that finds a valid line with an equal tag has `cpu_stall` low in its presentation cycle, returns the stored word on `cpu_rdata`, and starts no memory transaction.
- R4: A load that misses holds `cpu_stall` high for 2 + L cycles, where L is the number of cycles memory keeps `mem_req` waiting before `mem_ready`. During that time it performs exactly one memory read at the word-aligned address, with the low 2 bits zero. In the first unstalled cycle it returns the memory word on `cpu_rdata`.
- R5: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` do not change, and `mem_req` stays high.
- R6: Every store holds `cpu_stall` high for 2 + L cycles. It performs exactly one memory write (`mem_we` = 1) carrying the word-aligned address and the store data, and leaves stall low in the cycle after the acknowledge.
- R7: A store that hits replaces the cached word, so a following load to that address hits and returns the new data.
- R8: A store that misses allocates nothing. The line keeps its previous tag and data, and a later load to the stored address misses and fetches the written word from memory.
- R9: Two addresses with the same index and different tags evict each other, so alternating loads to them miss every time.
- R10: The byte offset bits are ignored: loads that differ only in address bits 1:0 hit the same line and return the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when the access completes |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | DATA_W | Memory read data, sampled with `mem_ready` |

## Verification
A load hit is due combinationally, so the bench samples stall and read data 1 ns after driving the request on the falling edge. For a miss or a store, the bench counts the falling-edge samples in which stall stays high. It compares that count with 2 plus the memory latency it programmed, and only then samples the returned word and the recorded memory transaction. The memory model acknowledges after 0 to 3 waiting cycles, varied per access, so every path is timed at several latencies. Lines, tags and byte offsets of a four-line configuration are swept, with expected hits computed from a shadow valid/tag table.

// File: rtl/dmc_pkg.sv
// Shared definitions for the direct-mapped cache controller.
package dmc_pkg;
    // Controller sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,  // serve hits, detect misses and stores
        ST_FETCH   = 2'd1,  // memory read in flight for a load miss
        ST_STORE   = 2'd2,  // memory write in flight
        ST_RELEASE = 2'd3   // one unstalled cycle that retires a store
    } dmc_state_e;
endpackage

// File: rtl/dmc_line_store.sv
// Line array: valid flags (reset), tags and data words (no reset).
// Assumes fill_en and upd_en are never high together; one shared index
// serves both the lookup read and the write.
module dmc_line_store #(
    parameter int INDEX_W = 10,
    parameter int TAG_W   = 20,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] index,
    input  logic               fill_en,
    input  logic               upd_en,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Valid flags: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[index] <= 1'b1;
        end
    end

    // Tag written on fill; data written on fill or store-hit update.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[index] <= wr_tag;
        end
        if (fill_en || upd_en) begin
            data_q[index] <= wr_data;
        end
    end

    // Combinational read of the indexed line.
    always_comb begin
        rd_valid = valid_q[index];
        rd_tag   = tag_q[index];
        rd_data  = data_q[index];
    end

    AST_UPD_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> valid_q[index]);  // R7
    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_q[$past(index)]);  // R4
endmodule

// File: rtl/dmc_lookup.sv
// Hit detection: the line is valid and its stored tag equals the request tag.
module dmc_lookup #(
    parameter int TAG_W = 20
) (
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit
);
    // Tag compare qualified by the valid flag.
    always_comb hit = line_valid && (line_tag == req_tag);
endmodule

// File: rtl/dmc_ctrl.sv
// Sequencer for misses and write-through stores. Assumes the processor
// holds its request while stalled. Latches the word address and store data
// so that the memory request stays stable until memory answers.
module dmc_ctrl #(
    parameter int WORD_W = 30,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [WORD_W-1:0] cpu_word,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              hit,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_word,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] look_word,
    output logic              fill_en,
    output logic              upd_en,
    output logic [DATA_W-1:0] line_wdata
);
    import dmc_pkg::*;

    dmc_state_e        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [DATA_W-1:0] wdata_q;

    // Next state and processor stall.
    always_comb begin
        state_d   = state_q;
        cpu_stall = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && cpu_we) begin
                    cpu_stall = 1'b1;
                    state_d   = ST_STORE;
                end else if (cpu_req && !hit) begin
                    cpu_stall = 1'b1;
                    state_d   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                cpu_stall = 1'b1;
                if (mem_ready) state_d = ST_IDLE;
            end
            ST_STORE: begin
                cpu_stall = 1'b1;
                if (mem_ready) state_d = ST_RELEASE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request when a memory transaction is about to start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && cpu_stall) begin
            word_q  <= cpu_word;
            wdata_q <= cpu_wdata;
        end
    end

    // Memory request, lookup address and line write controls.
    always_comb begin
        mem_req    = (state_q == ST_FETCH) || (state_q == ST_STORE);
        mem_we     = (state_q == ST_STORE);
        mem_word   = word_q;
        mem_wdata  = wdata_q;
        look_word  = (state_q == ST_IDLE) ? cpu_word : word_q;
        fill_en    = (state_q == ST_FETCH) && mem_ready;
        upd_en     = (state_q == ST_STORE) && mem_ready && hit;
        line_wdata = (state_q == ST_FETCH) ? mem_rdata : wdata_q;
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_word)
                                     && $stable(mem_we) && $stable(mem_wdata)));  // R5
    AST_STORE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> cpu_stall);  // R6
    AST_STORE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=> !cpu_stall);  // R6
    AST_NO_STORE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !mem_we);  // R8
    AST_REQ_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(cpu_stall));  // R2
endmodule

// File: rtl/dmc_cache.sv
// Direct-mapped, write-through, one word per line cache controller.
// Assumes word-aligned full-word accesses; byte offset bits are ignored.
// The processor holds its request while cpu_stall is high.
module dmc_cache #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFFS_W = $clog2(DATA_W / 8);
    localparam int WORD_W = ADDR_W - OFFS_W;
    localparam int TAG_W  = WORD_W - INDEX_W;

    logic [WORD_W-1:0] cpu_word, look_word, mem_word;
    logic [DATA_W-1:0] line_wdata;
    logic              hit, fill_en, upd_en, line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic              unused_offset;

    // Drop the byte offset; only the word address is used.
    always_comb begin
        cpu_word      = cpu_addr[ADDR_W-1:OFFS_W];
        unused_offset = ^cpu_addr[OFFS_W-1:0];
        mem_addr      = {mem_word, {OFFS_W{1'b0}}};
    end

    dmc_ctrl #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_word   (cpu_word),
        .cpu_wdata  (cpu_wdata),
        .hit        (hit),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .cpu_stall  (cpu_stall),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_word   (mem_word),
        .mem_wdata  (mem_wdata),
        .look_word  (look_word),
        .fill_en    (fill_en),
        .upd_en     (upd_en),
        .line_wdata (line_wdata)
    );

    dmc_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .index    (look_word[INDEX_W-1:0]),
        .fill_en  (fill_en),
        .upd_en   (upd_en),
        .wr_tag   (look_word[WORD_W-1:INDEX_W]),
        .wr_data  (line_wdata),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_data  (cpu_rdata)
    );

    dmc_lookup #(.TAG_W(TAG_W)) u_lookup (
        .line_valid (line_valid),
        .line_tag   (line_tag),
        .req_tag    (look_word[WORD_W-1:INDEX_W]),
        .hit        (hit)
    );

    AST_REPLAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready && cpu_req && !cpu_we)
        |=> (!cpu_req || cpu_we || (cpu_addr != $past(cpu_addr))
             || (!cpu_stall && cpu_rdata == $past(mem_rdata))));  // R4
endmodule

// File: tb/dmc_cache_test.sv
module dmc_cache_test;
    localparam int IW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int lat = 0, mem_cnt = 0, n_ops = 0, hold_err = 0;
    logic        pend = 1'b0;
    logic [31:0] p_addr, p_wdata, last_addr, last_wdata;
    logic        p_we, last_we;
    logic [31:0] bmem [64];
    logic        bv [4];
    logic [27:0] bt [4];

    always #2 clk = ~clk;

    dmc_cache #(.ADDR_W(32), .DATA_W(32), .INDEX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata)
    );

    // Memory model: acknowledge after lat waiting cycles, record transactions.
    always @(negedge clk) begin
        if (!rst_n || mem_ready) begin
            mem_ready = 1'b0;
            mem_cnt   = 0;
            pend      = 1'b0;
        end else if (mem_req) begin
            if (pend && (mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wdata))
                hold_err++;
            pend = 1'b1; p_addr = mem_addr; p_we = mem_we; p_wdata = mem_wdata;
            if (mem_cnt >= lat) begin
                mem_ready  = 1'b1;
                mem_rdata  = bmem[mem_addr[7:2]];
                if (mem_we) bmem[mem_addr[7:2]] = mem_wdata;
                last_addr  = mem_addr; last_we = mem_we; last_wdata = mem_wdata;
                n_ops++;
            end else begin
                mem_cnt++;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d expected below 150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int tg, input int idx, input int off);
        return 32'((tg << 4) | (idx << 2) | off);
    endfunction

    // One processor access with checks; req names the requirement under test.
    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd, input string req);
        int idx = int'(a[3:2]);
        int w   = int'(a[7:2]);
        bit exp_hit = bv[idx] && (bt[idx] == a[31:4]);
        int ops0 = n_ops;
        int stalls = 1;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        if (!we && exp_hit) begin
            chk(cpu_stall == 1'b0, req, 32'(cpu_stall), 32'd0);
            chk(cpu_rdata == bmem[w], req, cpu_rdata, bmem[w]);
            @(negedge clk);
            cpu_req = 1'b0;
            chk(n_ops == ops0, req, 32'(n_ops - ops0), 32'd0);
        end else begin
            chk(cpu_stall == 1'b1, req, 32'(cpu_stall), 32'd1);
            for (int k = 0; k < 40; k++) begin
                @(negedge clk); #1;
                if (!cpu_stall) break;
                stalls++;
            end
            chk(stalls == 2 + lat, req, 32'(stalls), 32'(2 + lat));
            chk(n_ops == ops0 + 1 && last_we == we && last_addr == {a[31:2], 2'b00},
                req, last_addr, {a[31:2], 2'b00});
            if (we) begin
                chk(last_wdata == wd, req, last_wdata, wd);
                if (exp_hit) bv[idx] = 1'b1;
            end else begin
                chk(cpu_rdata == bmem[w], req, cpu_rdata, bmem[w]);
                bv[idx] = 1'b1; bt[idx] = a[31:4];
            end
            @(negedge clk);
            cpu_req = 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) bmem[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0103;
        for (int i = 0; i < 4; i++) begin bv[i] = 1'b0; bt[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        // R2: idle outputs after reset
        chk(cpu_stall == 1'b0 && mem_req == 1'b0, "R2", {cpu_stall, mem_req}, 32'd0);

        // R2, R4, R3: first load of each line misses, repeat hits
        for (int i = 0; i < 4; i++) begin
            lat = i;
            access(1'b0, mk(0, i, 0), 32'd0, "R2");
            access(1'b0, mk(0, i, 0), 32'd0, "R3");
        end
        // R10: byte offsets ignored
        for (int i = 0; i < 4; i++)
            for (int off = 1; off < 4; off++)
                access(1'b0, mk(0, i, off), 32'd0, "R10");
        // R9: ping-pong between two tags on each index
        for (int i = 0; i < 4; i++)
            for (int r = 0; r < 3; r++) begin
                lat = (i + r) % 4;
                access(1'b0, mk(1, i, 0), 32'd0, "R9");
                access(1'b0, mk(2, i, 0), 32'd0, "R9");
            end
        // R6, R7: store hit updates cache and memory
        for (int i = 0; i < 4; i++) begin
            lat = 3 - i;
            access(1'b1, mk(2, i, 0), 32'hA5A5_0000 + 32'(i), "R6");
            access(1'b0, mk(2, i, 0), 32'd0, "R7");
        end
        // R8: store miss does not allocate
        for (int i = 0; i < 4; i++) begin
            lat = i;
            access(1'b1, mk(5, i, 0), 32'hC3C3_0000 + 32'(i), "R8");
            access(1'b0, mk(2, i, 0), 32'd0, "R8");
            access(1'b0, mk(5, i, 0), 32'd0, "R8");
        end
        // R1: sweep of tags and indices
        for (int t = 0; t < 16; t++)
            for (int i = 0; i < 4; i++) begin
                lat = (t + i) % 4;
                access(1'b0, mk(t, i, t % 4), 32'd0, "R1");
                access(1'b0, mk(t, i, 0), 32'd0, "R1");
            end
        // R5: request held stable while waiting
        chk(hold_err == 0, "R5", 32'(hold_err), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule